// File: doc/BRIEF.md
# Pipelined Split-Recursive Squarer

The block returns the exact 32-bit square of a 16-bit unsigned operand without any multiply operator. The operand is cut into four 4-bit nibbles. Each nibble is squared by a 16-entry constant table with 8-bit entries. Each cross term between two nibbles comes from a 4x4 shift-and-add product.

The square of each 8-bit half is rebuilt from the squares of its two nibbles and their doubled, shifted cross product. The 16-bit square is then rebuilt the same way from the two 8-bit squares and an 8x8 cross product. That 8x8 product is assembled from four nibble products.

One register stage follows each level of this recursion. A new operand may enter on every clock, and the result leaves three clocks later with its own valid flag. The intended user is an iterative fractal evaluator that only needs self-products.

Top module: `split_squarer`

## Requirements
- R1: When `valid_o` is high, `result_o` equals the unsigned square of the operand that produced it, for any 16-bit operand; bit 1 of such a result is always 0.
- R2: Each nibble table maps a 4-bit value x to x*x in 8 bits (3 gives 9, 15 gives 225); bit 1 of every entry is 0.
- R3: An operand sampled with `valid_i` high at a rising edge appears on `result_o` with `valid_o` high after the third rising edge, counting the sampling edge as the first.
- R4: Operands presented on consecutive cycles give results on consecutive cycles, in the same order.
- R5: `valid_o` reproduces the pattern of `valid_i` delayed by three cycles, gaps included. Every 4x4 cross product is zero exactly when one of its factors is zero.
- R6: While `valid_o` is low, `result_o` keeps the last result it showed.
- R7: Driving `rst_ni` low clears `valid_o` and `result_o` to 0 at once, without waiting for a clock, and discards the operands in flight.
- R8: Operand 0 gives 0, operand 0xFFFF gives 0xFFFE0001, and the one-sided operands 0x00FF, 0xFF00 and 0x0100 give their exact squares.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand present this cycle |
| op_i | input | 16 | Unsigned operand |
| valid_o | output | 1 | Result present |
| result_o | output | 32 | Square of the operand |

## Verification
A result can leave the pipeline in the same cycle that a new operand enters, and three operands can be in flight at once. Long back-to-back bursts mixed with random gaps provoke this overlap. Each output cycle is judged against the operand the bench recorded three cycles earlier, and the output is also checked to hold steady during the gaps. A reset in the middle of a burst checks that the operands in flight are dropped and do not emerge later.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int unsigned LEAF_W = 4;

  // square by shift-and-add, used only to fill constant tables
  function automatic logic [2*LEAF_W-1:0] sq_by_add(input logic [LEAF_W-1:0] x);
    logic [2*LEAF_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < LEAF_W; i++)
      if (x[i]) acc = acc + ({{LEAF_W{1'b0}}, x} << i);
    return acc;
  endfunction
endpackage

// File: rtl/sq_leaf.sv
module sq_leaf #(
  parameter int unsigned LW = sq_pkg::LEAF_W
) (
  input  logic [LW-1:0]   addr_i,
  output logic [2*LW-1:0] sq_o
);
  localparam int unsigned ENTRIES = 1 << LW;
  logic [2*LW-1:0] rom [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign rom[g] = sq_pkg::sq_by_add(LW'(g));
  end

  assign sq_o = rom[addr_i];
endmodule

// File: rtl/sq_mul.sv
module sq_mul #(
  parameter int unsigned W = sq_pkg::LEAF_W
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  always_comb begin
    p_o = '0;
    for (int i = 0; i < W; i++)
      if (b_i[i]) p_o = p_o + ({{W{1'b0}}, a_i} << i);
  end
endmodule

// File: rtl/sq_join.sv
module sq_join #(
  parameter int unsigned K = 4
) (
  input  logic [2*K-1:0] hi_sq_i,
  input  logic [2*K-1:0] lo_sq_i,
  input  logic [2*K-1:0] cross_i,
  output logic [4*K-1:0] sq_o
);
  // hi^2*2^2K + lo^2 is a plain concatenation; cross term doubled and shifted by K
  logic [4*K-1:0] mid;
  assign mid  = {{(2*K-1){1'b0}}, cross_i, 1'b0} << K;
  assign sq_o = {hi_sq_i, lo_sq_i} + mid;
endmodule

// File: rtl/split_squarer.sv
module split_squarer #(
  parameter int unsigned LEAF_W = sq_pkg::LEAF_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [4*LEAF_W-1:0]   op_i,
  output logic                  valid_o,
  output logic [8*LEAF_W-1:0]   result_o
);
  localparam int unsigned OP_W   = 4 * LEAF_W;
  localparam int unsigned HALF_W = 2 * LEAF_W;
  localparam int unsigned RES_W  = 2 * OP_W;
  localparam int unsigned NLEAF  = 4;
  localparam int unsigned NPROD  = 6;
  // nibble pairs: 0:(1,0) 1:(3,2) 2:(3,1) 3:(3,0) 4:(2,1) 5:(2,0)
  localparam int PA [NPROD] = '{1, 3, 3, 3, 2, 2};
  localparam int PB [NPROD] = '{0, 2, 1, 0, 1, 0};

  // ---- level 1: nibble squares and nibble products
  logic [LEAF_W-1:0]   nib  [NLEAF];
  logic [HALF_W-1:0]   lsq  [NLEAF];
  logic [HALF_W-1:0]   prod [NPROD];
  logic                s1_v;
  logic [HALF_W-1:0]   s1_lsq  [NLEAF];
  logic [HALF_W-1:0]   s1_prod [NPROD];

  for (genvar i = 0; i < NLEAF; i++) begin : g_leaf
    assign nib[i] = op_i[i*LEAF_W +: LEAF_W];
    sq_leaf #(.LW(LEAF_W)) u_leaf (.addr_i(nib[i]), .sq_o(lsq[i]));

    a_r2_leaf_bit1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |-> (!lsq[i][1] && lsq[i] <= HALF_W'(225)));
  end

  for (genvar j = 0; j < NPROD; j++) begin : g_prod
    sq_mul #(.W(LEAF_W)) u_mul (.a_i(nib[PA[j]]), .b_i(nib[PB[j]]), .p_o(prod[j]));

    a_r5_prod_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |-> ((prod[j] == '0) == (nib[PA[j]] == '0 || nib[PB[j]] == '0)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v <= 1'b0;
      for (int i = 0; i < NLEAF; i++) s1_lsq[i]  <= '0;
      for (int j = 0; j < NPROD; j++) s1_prod[j] <= '0;
    end else begin
      s1_v <= valid_i;
      if (valid_i) begin
        for (int i = 0; i < NLEAF; i++) s1_lsq[i]  <= lsq[i];
        for (int j = 0; j < NPROD; j++) s1_prod[j] <= prod[j];
      end
    end
  end

  // ---- level 2: half squares and half cross product
  logic [OP_W-1:0]   sq_lo, sq_hi, cross8;
  logic [HALF_W:0]   mid_sum;
  logic              s2_v;
  logic [OP_W-1:0]   s2_lo, s2_hi, s2_cross;

  sq_join #(.K(LEAF_W)) u_join_lo (
    .hi_sq_i(s1_lsq[1]), .lo_sq_i(s1_lsq[0]), .cross_i(s1_prod[0]), .sq_o(sq_lo));
  sq_join #(.K(LEAF_W)) u_join_hi (
    .hi_sq_i(s1_lsq[3]), .lo_sq_i(s1_lsq[2]), .cross_i(s1_prod[1]), .sq_o(sq_hi));

  assign mid_sum = {1'b0, s1_prod[3]} + {1'b0, s1_prod[4]};
  assign cross8  = {s1_prod[2], s1_prod[5]}
                 + ({{(OP_W-HALF_W-1){1'b0}}, mid_sum} << LEAF_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_v     <= 1'b0;
      s2_lo    <= '0;
      s2_hi    <= '0;
      s2_cross <= '0;
    end else begin
      s2_v <= s1_v;
      if (s1_v) begin
        s2_lo    <= sq_lo;
        s2_hi    <= sq_hi;
        s2_cross <= cross8;
      end
    end
  end

  // ---- level 3: full square
  logic [RES_W-1:0] sq_full;

  sq_join #(.K(HALF_W)) u_join_top (
    .hi_sq_i(s2_hi), .lo_sq_i(s2_lo), .cross_i(s2_cross), .sq_o(sq_full));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= s2_v;
      if (s2_v) result_o <= sq_full;
    end
  end

  // ---- checks
  logic [1:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  a_r3_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3) |-> (valid_o == $past(valid_i, 3)));

  a_r1_bit1_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !result_o[1]);

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(result_o));
endmodule

// File: tb/split_squarer_tb_top.sv
module split_squarer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_in = 1'b0;
  logic [15:0] op_in = '0;
  logic        valid_out;
  logic [31:0] result_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // history of driven inputs, index 0 = most recent
  bit          hv [4];
  logic [15:0] hd [4];
  logic [31:0] last_res = '0;

  always #2.5 clk = ~clk;

  split_squarer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_in), .op_i(op_in),
    .valid_o(valid_out), .result_o(result_out));

  function automatic logic [31:0] ref_sq(input logic [15:0] x);
    longint unsigned v;
    v = longint'(x) * longint'(x);
    return v[31:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_hist();
    for (int i = 0; i < 4; i++) begin hv[i] = 1'b0; hd[i] = '0; end
  endtask

  // one cycle: check output for operand driven three cycles ago, then drive new
  task automatic step(input bit v, input logic [15:0] d);
    @(negedge clk);
    if (hv[2]) begin
      check(valid_out == 1'b1, "R3/R4 valid", {31'b0, valid_out}, 32'd1);
      check(result_out == ref_sq(hd[2]), "R1 square", result_out, ref_sq(hd[2]));
      last_res = ref_sq(hd[2]);
    end else begin
      check(valid_out == 1'b0, "R5 gap", {31'b0, valid_out}, 32'd0);
      check(result_out == last_res, "R6 hold", result_out, last_res);
    end
    for (int i = 3; i > 0; i--) begin hv[i] = hv[i-1]; hd[i] = hd[i-1]; end
    hv[0] = v; hd[0] = d;
    valid_in = v;
    op_in = d;
  endtask

  task automatic flush();
    for (int i = 0; i < 4; i++) step(1'b0, '0);
  endtask

  initial begin
    clear_hist();
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check(valid_out == 1'b0, "R7 reset valid", {31'b0, valid_out}, 32'd0);
    check(result_out == '0, "R7 reset result", result_out, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R8 corners, back to back (R4)
    step(1'b1, 16'h0000);
    step(1'b1, 16'hFFFF);
    step(1'b1, 16'h00FF);
    step(1'b1, 16'hFF00);
    step(1'b1, 16'h0100);
    step(1'b1, 16'h0101);
    step(1'b1, 16'h0F0F);
    step(1'b1, 16'hF0F0);
    flush();

    // R2 each nibble table entry, placed in every nibble position
    for (int x = 0; x < 16; x++)
      for (int p = 0; p < 4; p++)
        step(1'b1, 16'(x) << (4 * p));
    flush();

    // direct nibble spot checks R2: 3 -> 9, 15 -> 225
    step(1'b1, 16'h0003);
    step(1'b1, 16'h000F);
    step(1'b0, 16'h0000);
    @(negedge clk);
    check(result_out == 32'd9, "R2 table 3", result_out, 32'd9);
    hv[3] = hv[2]; hd[3] = hd[2];
    for (int i = 2; i > 0; i--) begin hv[i] = hv[i-1]; hd[i] = hd[i-1]; end
    hv[0] = 1'b0; hd[0] = '0; valid_in = 1'b0;
    @(negedge clk);
    check(result_out == 32'd225, "R2 table 15", result_out, 32'd225);
    last_res = 32'd225;
    clear_hist();
    flush();

    // random mix of bursts and gaps (R1, R4, R5, R6)
    for (int n = 0; n < 3000; n++) begin
      bit v;
      v = ($urandom % 4) != 0;
      step(v, 16'($urandom));
    end
    flush();

    // R7 reset mid-burst drops in-flight operands
    step(1'b1, 16'h1234);
    step(1'b1, 16'h4321);
    #1;
    rst_n = 1'b0;
    #1;
    check(valid_out == 1'b0, "R7 async valid", {31'b0, valid_out}, 32'd0);
    check(result_out == '0, "R7 async result", result_out, 32'd0);
    valid_in = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    clear_hist();
    last_res = '0;
    flush();
    step(1'b1, 16'hABCD);
    flush();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule